// File: doc/BRIEF.md
# Signed Integer to Half-Precision Converter

This block turns one signed integer into an IEEE half-precision floating-point value. The integer is either 32 or 64 bits wide. The 16-bit result is written into the lowest lane of a 128-bit vector. All other lanes come unchanged from a first source vector. Any destination bits above bit 127 are driven to zero.

The rounding mode is chosen separately for each operation. An embedded field overrides the global field, but only for register-sourced operands that have the override enabled. Inexact results raise a precision flag. Results too large for half precision raise both the overflow flag and the precision flag. An unmasked overflow also raises an exception signal.

A three-state controller sequences each operation:
- **S_IDLE**: `in_ready` is high and the operation's inputs are captured.
- **S_CALC**: the captured integer passes through magnitude extraction, a leading-zero count and rounding, and the result is registered.
- **S_DONE**: `out_valid` pulses for one cycle.

The transitions are:
- **accept**: S_IDLE to S_CALC when `in_valid` is high.
- **compute**: S_CALC to S_DONE, unconditional.
- **release**: S_DONE to S_IDLE, unconditional.

Top module: `int2half_cvt`

## Requirements
- R1: The 64-bit integer is used only when both `mode64` and `opsize64` are 1. Otherwise bits 31:0 of `int_src` are taken as a signed 32-bit value, and bits 63:32 have no effect.
- R2: The rounding mode comes from `emb_rnd` only when `src_is_reg` and `emb_rnd_en` are both 1. In every other case it comes from `glb_rnd`.
- R3: The rounding encoding is 00 round-to-nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero. The result has sign in bit 15, a 5-bit exponent (bias 15) in bits 14:10, and a 10-bit fraction in bits 9:0.
- R4: An exactly representable integer converts with both flags clear. Zero converts to 16'h0000 with no flags.
- R5: An inexact, non-overflowing result sets `prec_flag` and leaves `ovf_flag` clear.
- R6: A rounded magnitude above 65504 sets both `ovf_flag` and `prec_flag`. The result is then chosen by mode:
  - nearest-even gives a signed infinity;
  - toward-zero gives ±65504 (16'h7BFF or 16'hFBFF);
  - toward negative infinity gives -infinity for negative inputs and +65504 for positive ones;
  - toward positive infinity gives +infinity for positive inputs and -65504 for negative ones.
  
  This includes the most negative 32-bit and 64-bit values.
- R7: `exc_raise` equals `ovf_flag` AND NOT the captured `ovf_mask`.
- R8: `dst_vec[15:0]` holds the result, `dst_vec[127:16]` equals `src_vec[127:16]` as captured, and `dst_vec` bits above 127 are zero.
- R9: An operation is accepted when `in_valid` is high while `in_ready` is high. `out_valid` is high for exactly one cycle, two clock edges after the accepting edge. `in_valid` has no effect while `in_ready` is low.
- R10: After reset, `in_ready` is 1, and `out_valid`, the flags and `dst_vec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | High in S_IDLE |
| src_vec | input | 128 | First source vector |
| int_src | input | 64 | Integer source |
| opsize64 | input | 1 | Operand size is 64 bits |
| mode64 | input | 1 | 64-bit mode active |
| src_is_reg | input | 1 | Integer came from a register |
| emb_rnd_en | input | 1 | Embedded rounding enable |
| emb_rnd | input | 2 | Embedded rounding mode |
| glb_rnd | input | 2 | Global rounding mode |
| ovf_mask | input | 1 | Overflow exception mask |
| out_valid | output | 1 | Result pulse |
| dst_vec | output | DST_W | Merged destination |
| ovf_flag | output | 1 | Overflow status |
| prec_flag | output | 1 | Precision status |
| exc_raise | output | 1 | Unmasked overflow exception |

## Verification
A controller stuck outside S_IDLE shows at once as `in_ready` staying low and no `out_valid`. A controller that skips S_CALC or lingers in S_DONE shows within one cycle, as a misplaced or doubled `out_valid` pulse. A wrong captured mode, width bit or mask shows only in that operation's result and flags, at its `out_valid` cycle. Tie values, directed-mode overflows and width-select patterns are therefore driven so that each such fault changes a visible result bit.

// File: rtl/i2h_pkg.sv
package i2h_pkg;
    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    localparam int HALF_FRAC_W = 10;
    localparam int HALF_BIAS   = 15;
    localparam int HALF_EMAX   = 15;

    typedef struct packed {
        logic        ovf;
        logic        inexact;
        logic [15:0] bits;
    } half_res_t;
endpackage

// File: rtl/i2h_mag.sv
module i2h_mag #(
    parameter int INT_W = 64,
    parameter int NARROW_W = 32
) (
    input  logic [INT_W-1:0] int_src,
    input  logic             sel_wide,
    output logic [INT_W-1:0] mag,
    output logic             neg,
    output logic             is_zero
);
    logic [INT_W-1:0] ext;

    always_comb begin
        ext     = sel_wide ? int_src
                           : {{(INT_W-NARROW_W){int_src[NARROW_W-1]}}, int_src[NARROW_W-1:0]};
        neg     = ext[INT_W-1];
        mag     = neg ? (~ext + 1'b1) : ext;
        is_zero = (ext == '0);
    end
endmodule

// File: rtl/i2h_lzc.sv
module i2h_lzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        cnt   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                cnt   = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2h_round.sv
module i2h_round
    import i2h_pkg::*;
#(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  mag,
    input  logic          neg,
    input  logic          is_zero,
    input  logic [CW-1:0] lz,
    input  rnd_mode_e     mode,
    output half_res_t     res
);
    localparam int EW = CW + 1;

    logic [W-1:0]           norm;
    logic [HALF_FRAC_W-1:0] frac_raw;
    logic                   guard, sticky, inc, carry, to_inf;
    logic [11:0]            mant;
    logic [EW-1:0]          e_unb, e_fin;

    always_comb begin
        norm     = mag << lz;
        e_unb    = EW'(W - 1) - EW'(lz);
        frac_raw = norm[W-2 -: HALF_FRAC_W];
        guard    = norm[W-2-HALF_FRAC_W];
        sticky   = |norm[W-3-HALF_FRAC_W:0];
        unique case (mode)
            RND_NEAR: inc = guard & (sticky | frac_raw[0]);
            RND_DOWN: inc = neg & (guard | sticky);
            RND_UP:   inc = ~neg & (guard | sticky);
            RND_ZERO: inc = 1'b0;
        endcase
        mant   = {2'b01, frac_raw} + 12'(inc);
        carry  = mant[11];
        e_fin  = e_unb + EW'(carry);
        to_inf = (mode == RND_NEAR) || (mode == RND_DOWN && neg) || (mode == RND_UP && !neg);

        res = '0;
        if (!is_zero) begin
            res.inexact = guard | sticky;
            if (e_fin > EW'(HALF_EMAX)) begin
                res.ovf     = 1'b1;
                res.inexact = 1'b1;
                res.bits    = to_inf ? {neg, 5'h1F, 10'h000} : {neg, 5'h1E, 10'h3FF};
            end else begin
                res.bits = {neg, 5'(e_fin + EW'(HALF_BIAS)),
                            carry ? 10'h000 : mant[HALF_FRAC_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/int2half_cvt.sv
module int2half_cvt
    import i2h_pkg::*;
#(
    parameter int DST_W = 256,
    parameter int INT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [127:0]     src_vec,
    input  logic [INT_W-1:0] int_src,
    input  logic             opsize64,
    input  logic             mode64,
    input  logic             src_is_reg,
    input  logic             emb_rnd_en,
    input  logic [1:0]       emb_rnd,
    input  logic [1:0]       glb_rnd,
    input  logic             ovf_mask,
    output logic             out_valid,
    output logic [DST_W-1:0] dst_vec,
    output logic             ovf_flag,
    output logic             prec_flag,
    output logic             exc_raise
);
    localparam int CW = $clog2(INT_W);

    typedef enum logic [1:0] {S_IDLE, S_CALC, S_DONE} state_e;
    state_e state, state_nx;

    logic [127:16]    upper_q;
    logic [INT_W-1:0] int_q;
    logic             wide_q, mask_q;
    rnd_mode_e        mode_q;
    logic [127:0]     dst_q;
    logic             ovf_q, prec_q;

    logic [INT_W-1:0] mag;
    logic             neg, is_zero;
    logic [CW-1:0]    lz;
    half_res_t        res;
    logic             unused_lo;

    assign unused_lo = ^src_vec[15:0];

    i2h_mag   #(.INT_W(INT_W)) u_mag (.int_src(int_q), .sel_wide(wide_q),
                                      .mag(mag), .neg(neg), .is_zero(is_zero));
    i2h_lzc   #(.W(INT_W))     u_lzc (.vec(mag), .cnt(lz));
    i2h_round #(.W(INT_W))     u_rnd (.mag(mag), .neg(neg), .is_zero(is_zero),
                                      .lz(lz), .mode(mode_q), .res(res));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (in_valid) state_nx = S_CALC;
            S_CALC: state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = (state == S_IDLE);
        out_valid = (state == S_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            int_q   <= '0;
            wide_q  <= 1'b0;
            mask_q  <= 1'b1;
            mode_q  <= RND_NEAR;
            dst_q   <= '0;
            ovf_q   <= 1'b0;
            prec_q  <= 1'b0;
        end else begin
            if (state == S_IDLE && in_valid) begin
                upper_q <= src_vec[127:16];
                int_q   <= int_src;
                wide_q  <= mode64 & opsize64;
                mask_q  <= ovf_mask;
                mode_q  <= rnd_mode_e'((src_is_reg && emb_rnd_en) ? emb_rnd : glb_rnd);
            end
            if (state == S_CALC) begin
                dst_q  <= {upper_q, res.bits};
                ovf_q  <= res.ovf;
                prec_q <= res.inexact;
            end
        end
    end

    assign ovf_flag  = ovf_q;
    assign prec_flag = prec_q;
    assign exc_raise = ovf_q & ~mask_q;

    generate
        if (DST_W > 128) begin : g_wide
            assign dst_vec = {{(DST_W-128){1'b0}}, dst_q};
        end else begin : g_exact
            assign dst_vec = dst_q;
        end
    endgenerate

    AST_ONE_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R9
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> (!in_ready && !out_valid)); // R9
    AST_OVF_HAS_PREC:   assert property (@(posedge clk) disable iff (!rst_n) (out_valid && ovf_flag) |-> prec_flag); // R6
    AST_EXC_NEEDS_OVF:  assert property (@(posedge clk) disable iff (!rst_n) exc_raise |-> ovf_flag); // R7
    AST_ZERO_CLEAN:     assert property (@(posedge clk) disable iff (!rst_n) (out_valid && dst_vec[15:0] == 16'h0) |-> (!ovf_flag && !prec_flag)); // R4
    AST_LANES_KEPT:     assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (dst_vec[127:16] == upper_q)); // R8
endmodule

// File: tb/int2half_cvt_test.sv
module int2half_cvt_test;
    localparam int DST_W = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [127:0]     src_vec = '0;
    logic [63:0]      int_src = '0;
    logic             opsize64 = 1'b0, mode64 = 1'b0, src_is_reg = 1'b0, emb_rnd_en = 1'b0;
    logic [1:0]       emb_rnd = 2'b00, glb_rnd = 2'b00;
    logic             ovf_mask = 1'b1;
    logic             out_valid;
    logic [DST_W-1:0] dst_vec;
    logic             ovf_flag, prec_flag, exc_raise;

    int checks = 0;
    int fails  = 0;
    int pc     = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [127:0] lo;
        logic         ovf;
        logic         prec;
        logic         exc;
        int           due;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) pc <= pc + 1;

    int2half_cvt #(.DST_W(DST_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_vec(src_vec), .int_src(int_src), .opsize64(opsize64), .mode64(mode64),
        .src_is_reg(src_is_reg), .emb_rnd_en(emb_rnd_en), .emb_rnd(emb_rnd),
        .glb_rnd(glb_rnd), .ovf_mask(ovf_mask), .out_valid(out_valid),
        .dst_vec(dst_vec), .ovf_flag(ovf_flag), .prec_flag(prec_flag), .exc_raise(exc_raise)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] model(logic [63:0] x, logic w, logic [1:0] md);
        logic [63:0] v, m, q, rem, hp;
        logic neg, up;
        int p, sh;
        v   = w ? x : {{32{x[31]}}, x[31:0]};
        neg = v[63];
        m   = neg ? (64'd0 - v) : v;
        if (m == 0) return 18'h0;
        p = 0;
        for (int i = 0; i < 64; i++) if (m[i]) p = i;
        if (p <= 10) begin
            q = m << (10 - p);
            return {2'b00, neg, 5'(p + 15), q[9:0]};
        end
        sh  = p - 10;
        q   = m >> sh;
        rem = m & ((64'd1 << sh) - 64'd1);
        hp  = 64'd1 << (sh - 1);
        case (md)
            2'b00:   up = (rem > hp) || (rem == hp && q[0]);
            2'b01:   up = neg && rem != 0;
            2'b10:   up = !neg && rem != 0;
            default: up = 1'b0;
        endcase
        q = q + 64'(up);
        if (q == 64'd2048) begin
            q = 64'd1024;
            p++;
        end
        if (p > 15) begin
            if (md == 2'b00 || (md == 2'b01 && neg) || (md == 2'b10 && !neg))
                return {2'b11, neg, 5'h1F, 10'h000};
            return {2'b11, neg, 5'h1E, 10'h3FF};
        end
        return {1'b0, rem != 0, neg, 5'(p + 15), q[9:0]};
    endfunction

    task automatic send(input logic [127:0] v, input logic [63:0] x, input logic o64, input logic m64,
                        input logic rg, input logic een, input logic [1:0] er, input logic [1:0] gr,
                        input logic msk, input string tag);
        exp_t e;
        logic [1:0] md;
        logic [17:0] r;
        md = (rg && een) ? er : gr;
        r  = model(x, o64 && m64, md);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        src_vec = v; int_src = x; opsize64 = o64; mode64 = m64; src_is_reg = rg;
        emb_rnd_en = een; emb_rnd = er; glb_rnd = gr; ovf_mask = msk; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e.lo   = {v[127:16], r[15:0]};
        e.ovf  = r[17];
        e.prec = r[16];
        e.exc  = r[17] & ~msk;
        e.due  = pc + 1;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // R9: requests while busy must be ignored
    task automatic poke_busy();
        @(negedge clk);
        while (in_ready) @(negedge clk);
        int_src = 64'h7FFF_FFFF; glb_rnd = 2'b00; mode64 = 1'b1; opsize64 = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 actual=unexpected out_valid expected=none");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " result"}, {112'h0, dst_vec[15:0]}, {112'h0, e.lo[15:0]});
                check({e.tag, " flags"}, {126'h0, ovf_flag, prec_flag}, {126'h0, e.ovf, e.prec});
                check("R7 exception", {127'h0, exc_raise}, {127'h0, e.exc});
                check("R8 lanes", dst_vec[127:0], e.lo);
                check("R8 upper zero", dst_vec[DST_W-1:128], 128'h0);
                check("R9 latency", 128'(pc), 128'(e.due));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] vv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 in_ready", {127'h0, in_ready}, 128'h1);
        check("R10 out_valid", {127'h0, out_valid}, 128'h0);
        check("R10 dst", dst_vec[127:0], 128'h0);
        check("R10 flags", {125'h0, ovf_flag, prec_flag, exc_raise}, 128'h0);

        vv = {4{32'hA5C3_1E77}};
        // R4 exact values and zero
        send(vv, 64'd0, 0, 0, 0, 0, 0, 2'b00, 1, "R4 zero");
        send(vv, 64'd1, 0, 0, 0, 0, 0, 2'b00, 1, "R4 one");
        send(vv, -64'sd1, 0, 0, 0, 0, 0, 2'b00, 1, "R4 minus one");
        send(vv, 64'd2048, 0, 0, 0, 0, 0, 2'b00, 1, "R4 2048");
        send(vv, 64'd65504, 0, 0, 0, 0, 0, 2'b11, 1, "R4 max finite");
        // R3 R5 rounding at ties and directed modes
        send(vv, 64'd2049, 0, 0, 0, 0, 0, 2'b00, 1, "R3 tie even down");
        send(vv, 64'd2051, 0, 0, 0, 0, 0, 2'b00, 1, "R3 tie even up");
        send(vv, 64'd2049, 0, 0, 0, 0, 0, 2'b10, 1, "R5 up");
        send(vv, -64'sd2049, 0, 0, 0, 0, 0, 2'b01, 1, "R5 down neg");
        send(vv, -64'sd2049, 0, 0, 0, 0, 0, 2'b10, 1, "R5 up neg");
        send(vv, 64'd2049, 0, 0, 0, 0, 0, 2'b11, 1, "R5 zero");
        send(vv, 64'd65519, 0, 0, 0, 0, 0, 2'b00, 1, "R5 below half");
        send(vv, 64'd65520, 0, 0, 0, 0, 0, 2'b00, 1, "R6 tie overflow");
        // R6 overflow by mode and sign
        for (int md = 0; md < 4; md++) begin
            send(vv, 64'd70000, 0, 0, 0, 0, 0, 2'(md), 1, "R6 pos");
            send(vv, -64'sd70000, 0, 0, 0, 0, 0, 2'(md), 1, "R6 neg");
        end
        send(vv, 64'h8000_0000_0000_0000, 1, 1, 0, 0, 0, 2'b11, 1, "R6 min64");
        send(vv, 64'h0000_0000_8000_0000, 0, 0, 0, 0, 0, 2'b00, 1, "R6 min32");
        // R7 mask
        send(vv, 64'd100000, 0, 0, 0, 0, 0, 2'b00, 0, "R7 unmasked");
        send(vv, 64'd100000, 0, 0, 0, 0, 0, 2'b00, 1, "R7 masked");
        // R1 width select
        send(vv, 64'h0000_0001_0000_0003, 1, 1, 0, 0, 0, 2'b00, 1, "R1 wide");
        send(vv, 64'h0000_0001_0000_0003, 1, 0, 0, 0, 0, 2'b00, 1, "R1 not mode64");
        send(vv, 64'h0000_0001_0000_0003, 0, 1, 0, 0, 0, 2'b00, 1, "R1 not opsize");
        send(vv, 64'h0000_0000_FFFF_FFFD, 0, 0, 0, 0, 0, 2'b00, 1, "R1 narrow neg");
        // R2 rounding source
        send(vv, 64'd2049, 0, 0, 1, 1, 2'b10, 2'b11, 1, "R2 embedded");
        send(vv, 64'd2049, 0, 0, 0, 1, 2'b10, 2'b11, 1, "R2 memory");
        send(vv, 64'd2049, 0, 0, 1, 0, 2'b10, 2'b11, 1, "R2 disabled");
        // R9 busy requests ignored
        send(vv, 64'd5, 0, 0, 0, 0, 0, 2'b00, 1, "R9 busy base");
        poke_busy();
        // R8 random lanes and values
        for (int k = 0; k < 60; k++) begin
            logic [63:0] x;
            logic [127:0] v;
            v = {$urandom, $urandom, $urandom, $urandom};
            x = {$urandom, $urandom} >> ($urandom % 64);
            if ($urandom % 2) x = -x;
            send(v, x, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), 2'($urandom), 1'($urandom), "R8 random");
        end
        repeat (6) @(negedge clk);
        check("R9 all results seen", 128'(sb.size()), 128'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule